// File: doc/BRIEF.md
# Pulse-Verify Word Programming Sequencer

This block writes a contiguous range of words into a one-time or UV-erasable memory array. Programming in such an array can only clear bits. The sequencer first raises the programming-supply enable and then handles one word at a time. For each word it reads the current contents. It rejects at once any word whose target needs a cleared bit to be set again. A word whose contents already match is skipped. Every other word gets a train of fixed-width program pulses, with a verify read after each pulse, until the word reads back correctly or the retry limit is reached.

When the last word of the range has verified, the supply enable drops. A second pass then reads every word of the range in normal read mode and compares it with the source image. The target words come from a plain source port: the sequencer presents an address and takes the data word back in the same cycle. All setup, pulse and hold intervals are counted in clock cycles, scaled by a cycles-per-microsecond parameter.

The status outputs report completion or failure, the cause of a failure, the address involved, and how many pulses the most recent word took.

Top module: `pvp_sequencer`

## Requirements
- R1: Each program pulse holds `mem_ce_n` low for exactly PULSE_US*CLK_PER_US cycles. During the pulse `mem_oe_n` is high, `mem_vpp_en` is high, `mem_data_oe` is high, and the address and write data do not change.
- R2: After each pulse a verify read drives `mem_ce_n` high and `mem_oe_n` low with `mem_vpp_en` still high, and compares `mem_rdata` with the target word. Chip-enable and output-enable are never low together while the supply enable is high.
- R3: The pulse count restarts at 0 for every word and counts the pulses applied to it. If a word still mismatches after MAX_PULSES pulses, the operation ends with `fail`=1, `fail_cause`=2, `fail_addr` set to that word and `pulses_used`=MAX_PULSES. A word that matches on the very last allowed pulse still succeeds.
- R4: A matching verify moves on to the next address. When all words from `first_addr` to `last_addr` (inclusive) verify and read back correctly, `done`=1, `fail_cause`=0, `pulses_used` equals the count spent on the last word, and every word in the range holds its source data.
- R5: The supply enable rises at least 2*SETUP_US*CLK_PER_US cycles before the first output-enable fall. Write data is driven and stable for at least SETUP_US*CLK_PER_US cycles before chip-enable falls.
- R6: Write data stays driven for at least HOLD_US*CLK_PER_US cycles after chip-enable rises. It is released at least SETUP_US*CLK_PER_US cycles before the next output-enable fall. It is never driven while output-enable is low.
- R7: If the pre-read of a word shows a 0 in a bit position where the target has a 1, the operation ends with `fail`=1, `fail_cause`=1, `fail_addr` set to that word and `pulses_used`=0. No pulse is applied to that word.
- R8: A word whose pre-read already equals its target receives no pulse, and its pulse count is 0.
- R9: The final pass reads each word with `mem_vpp_en` low and `mem_ce_n` and `mem_oe_n` low. Any mismatch ends the operation with `fail`=1, `fail_cause`=3 and `fail_addr` set to the mismatching word.
- R10: `busy` is high from the cycle after `start` until completion. `done` and `fail` are never high together, are both low while busy, and keep their values until the next `start`.
- R11: After reset, `busy`, `done`, `fail` and `mem_vpp_en` are low, and `mem_ce_n` and `mem_oe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run when idle |
| first_addr | input | ADDR_W | First word of the range |
| last_addr | input | ADDR_W | Last word of the range (inclusive) |
| src_addr | output | ADDR_W | Address of the requested source word |
| src_data | input | DATA_W | Source word for `src_addr`, same cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Data to program |
| mem_data_oe | output | 1 | Drive `mem_wdata` onto the memory data bus |
| mem_rdata | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Active-low chip enable (program pulse or read select) |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_vpp_en | output | 1 | Programming-supply enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with all words correct |
| fail | output | 1 | Run aborted |
| fail_cause | output | 2 | 1 cannot clear, 2 retries used up, 3 read-back mismatch |
| fail_addr | output | ADDR_W | Address of the failing word |
| pulses_used | output | PC_W | Pulses spent on the most recent word |

## Verification
Each memory-side interval is a fixed number of cycles. A pulse lasts PULSE_US*CLK_PER_US cycles, and the setup, hold and gap phases each last their scaled count. Cycle-counting monitors in the bench sample the pins at every rising edge and measure each interval from the edge where the controlling strobe changes. Completion status is registered and appears one cycle after the final read or the failing compare. Its exact cycle depends on the random pulse count of the memory model, so the bench polls `done`/`fail` on the falling edge. It then checks the status, the pulse count and the memory contents in that same sample, and checks again a few cycles later to confirm the status is held.

// File: rtl/pvp_pkg.sv
package pvp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VPP_UP,
    ST_ADDR_SET,
    ST_PRE_READ,
    ST_DATA_SET,
    ST_PULSE,
    ST_DATA_HOLD,
    ST_VFY_GAP,
    ST_VERIFY,
    ST_NEXT,
    ST_CHK_ADDR,
    ST_CHK_READ
  } pvp_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_BLANK    = 2'd1,
    CAUSE_RETRY    = 2'd2,
    CAUSE_READBACK = 2'd3
  } pvp_cause_e;

endpackage

// File: rtl/pvp_timer.sv
module pvp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_TIMER_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));  // R1

endmodule

// File: rtl/pvp_pulse_ctr.sv
module pvp_pulse_ctr #(
  parameter int MAX_PULSES = 25,
  parameter int PC_W       = $clog2(MAX_PULSES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  output logic [PC_W-1:0] count,
  output logic            at_max
);

  logic [PC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (inc && !at_max) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count  = cnt_q;
  assign at_max = (cnt_q == PC_W'(MAX_PULSES));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_max);  // R3

endmodule

// File: rtl/pvp_sequencer.sv
module pvp_sequencer
  import pvp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int CLK_PER_US = 200,
  parameter int SETUP_US   = 2,
  parameter int PULSE_US   = 50,
  parameter int HOLD_US    = 2,
  parameter int MAX_PULSES = 25,
  parameter int PC_W       = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_data_oe,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_vpp_en,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [1:0]        fail_cause,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [PC_W-1:0]   pulses_used
);

  localparam int T_SU  = (SETUP_US * CLK_PER_US < 1) ? 1 : SETUP_US * CLK_PER_US;
  localparam int T_PW  = (PULSE_US * CLK_PER_US < 1) ? 1 : PULSE_US * CLK_PER_US;
  localparam int T_HD  = (HOLD_US  * CLK_PER_US < 1) ? 1 : HOLD_US  * CLK_PER_US;
  localparam int T_MAX = (T_PW > T_SU) ? ((T_PW > T_HD) ? T_PW : T_HD)
                                       : ((T_SU > T_HD) ? T_SU : T_HD);
  localparam int CNT_W = $clog2(T_MAX + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  pvp_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] tgt_q, tgt_d;
  logic              done_q, done_d, fail_q, fail_d;
  pvp_cause_e        cause_q, cause_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              ctr_clr, ctr_inc, ctr_at_max;
  logic [PC_W-1:0]   ctr_count;

  function automatic logic [CNT_W-1:0] dwell(input pvp_state_e s);
    case (s)
      ST_PULSE:     dwell = CNT_W'(T_PW - 1);
      ST_DATA_HOLD: dwell = CNT_W'(T_HD - 1);
      ST_NEXT,
      ST_IDLE:      dwell = '0;
      default:      dwell = CNT_W'(T_SU - 1);
    endcase
  endfunction

  pvp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  pvp_pulse_ctr #(.MAX_PULSES(MAX_PULSES), .PC_W(PC_W)) u_pulse_ctr (
    .clk(clk), .rst_n(rst_n_s), .clr(ctr_clr), .inc(ctr_inc),
    .count(ctr_count), .at_max(ctr_at_max)
  );

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    tgt_d   = tgt_q;
    done_d  = done_q;
    fail_d  = fail_q;
    cause_d = cause_q;
    faddr_d = faddr_q;
    ctr_clr = 1'b0;
    ctr_inc = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_VPP_UP;
        done_d  = 1'b0;
        fail_d  = 1'b0;
        cause_d = CAUSE_NONE;
        ctr_clr = 1'b1;
      end
      ST_VPP_UP: if (tmr_zero) begin
        state_d = ST_ADDR_SET;
        addr_d  = first_addr;
      end
      ST_ADDR_SET: if (tmr_zero) begin
        state_d = ST_PRE_READ;
        tgt_d   = src_data;
      end
      ST_PRE_READ: if (tmr_zero) begin
        if ((~mem_rdata & tgt_q) != '0) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
          cause_d = CAUSE_BLANK;
          faddr_d = addr_q;
        end else if (mem_rdata == tgt_q) state_d = ST_NEXT;
        else                             state_d = ST_DATA_SET;
      end
      ST_DATA_SET:  if (tmr_zero) state_d = ST_PULSE;
      ST_PULSE: if (tmr_zero) begin
        state_d = ST_DATA_HOLD;
        ctr_inc = 1'b1;
      end
      ST_DATA_HOLD: if (tmr_zero) state_d = ST_VFY_GAP;
      ST_VFY_GAP:   if (tmr_zero) state_d = ST_VERIFY;
      ST_VERIFY: if (tmr_zero) begin
        if (mem_rdata == tgt_q) state_d = ST_NEXT;
        else if (ctr_at_max) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
          cause_d = CAUSE_RETRY;
          faddr_d = addr_q;
        end else state_d = ST_DATA_SET;
      end
      ST_NEXT: begin
        if (addr_q == last_addr) begin
          state_d = ST_CHK_ADDR;
          addr_d  = first_addr;
        end else begin
          state_d = ST_ADDR_SET;
          addr_d  = addr_q + 1'b1;
          ctr_clr = 1'b1;
        end
      end
      ST_CHK_ADDR: if (tmr_zero) state_d = ST_CHK_READ;
      ST_CHK_READ: if (tmr_zero) begin
        if (mem_rdata != src_data) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
          cause_d = CAUSE_READBACK;
          faddr_d = addr_q;
        end else if (addr_q == last_addr) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_CHK_ADDR;
          addr_d  = addr_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign tmr_val  = dwell(state_d);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      tgt_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
      faddr_q <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      tgt_q   <= tgt_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      cause_q <= cause_d;
      faddr_q <= faddr_d;
    end
  end

  assign src_addr    = addr_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = tgt_q;
  assign mem_vpp_en  = (state_q inside {ST_VPP_UP, ST_ADDR_SET, ST_PRE_READ, ST_DATA_SET,
                                        ST_PULSE, ST_DATA_HOLD, ST_VFY_GAP, ST_VERIFY, ST_NEXT});
  assign mem_ce_n    = !(state_q inside {ST_PULSE, ST_CHK_ADDR, ST_CHK_READ});
  assign mem_oe_n    = !(state_q inside {ST_PRE_READ, ST_VERIFY, ST_CHK_READ});
  assign mem_data_oe = (state_q inside {ST_DATA_SET, ST_PULSE, ST_DATA_HOLD});
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign fail        = fail_q;
  assign fail_cause  = cause_q;
  assign fail_addr   = faddr_q;
  assign pulses_used = ctr_count;

  AST_PULSE_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_vpp_en && !mem_ce_n) |-> (mem_data_oe && mem_oe_n));  // R1
  AST_PULSE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_vpp_en && !mem_ce_n && $past(mem_vpp_en && !mem_ce_n))
      |-> ($stable(mem_addr) && $stable(mem_wdata)));  // R1
  AST_NO_PROG_AND_READ: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_vpp_en |-> (mem_ce_n || mem_oe_n));  // R2
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mem_oe_n |-> !mem_data_oe);  // R6
  AST_RETRY_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(fail) && fail_cause == CAUSE_RETRY) |-> (pulses_used == PC_W'(MAX_PULSES)));  // R3
  AST_BLANK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(fail) && fail_cause == CAUSE_BLANK) |-> (pulses_used == '0));  // R7
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(done && fail));  // R10
  AST_BUSY_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |-> (!done && !fail));  // R10

endmodule

// File: tb/pvp_sequencer_tb_top.sv
`timescale 1ns/1ps
module pvp_sequencer_tb_top;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CPU = 2;
  localparam int MAXP = 25;
  localparam int PCW = 5;
  localparam int T_SU = 2 * CPU;
  localparam int T_PW = 50 * CPU;
  localparam int T_HD = 2 * CPU;
  localparam int NROWS = 7;

  typedef struct packed {
    logic [3:0] first;
    logic [3:0] last;
    logic [4:0] base;
    logic [1:0] step;
    logic [1:0] preset;     // 0 none, 1 zero word at last, 2 target at last
    logic       exp_fail;
    logic [1:0] exp_cause;
    logic [3:0] exp_addr;
    logic [4:0] exp_pulses;
  } row_t;

  localparam row_t ROWS [NROWS] = '{
    '{4'd0,  4'd3,  5'd3,  2'd0, 2'd0, 1'b0, 2'd0, 4'd0,  5'd3 },
    '{4'd4,  4'd7,  5'd1,  2'd2, 2'd0, 1'b0, 2'd0, 4'd0,  5'd7 },
    '{4'd8,  4'd9,  5'd24, 2'd1, 2'd0, 1'b0, 2'd0, 4'd0,  5'd25},
    '{4'd10, 4'd10, 5'd24, 2'd1, 2'd0, 1'b1, 2'd2, 4'd10, 5'd25},
    '{4'd11, 4'd12, 5'd1,  2'd0, 2'd1, 1'b1, 2'd1, 4'd12, 5'd0 },
    '{4'd13, 4'd13, 5'd1,  2'd0, 2'd2, 1'b0, 2'd0, 4'd0,  5'd0 },
    '{4'd14, 4'd15, 5'd2,  2'd0, 2'd0, 1'b0, 2'd0, 4'd0,  5'd2 }
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [DW-1:0] src_data, mem_wdata, mem_rdata;
  logic mem_data_oe, mem_ce_n, mem_oe_n, mem_vpp_en, busy, done, fail;
  logic [1:0] fail_cause;
  logic [PCW-1:0] pulses_used;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] img(input logic [AW-1:0] a);
    return 16'h5A3C ^ {4{a}};
  endfunction

  assign src_data = img(src_addr);

  pvp_sequencer #(.ADDR_W(AW), .DATA_W(DW), .CLK_PER_US(CPU), .MAX_PULSES(MAXP), .PC_W(PCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr), .last_addr(last_addr),
    .src_addr(src_addr), .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_data_oe(mem_data_oe), .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_vpp_en(mem_vpp_en), .busy(busy), .done(done), .fail(fail), .fail_cause(fail_cause),
    .fail_addr(fail_addr), .pulses_used(pulses_used)
  );

  // behavioural memory: bits clear only once a word has taken its needed pulses
  logic [DW-1:0] mem [16];
  int need [16];
  int pcnt [16];
  bit corrupt_en = 1'b0;
  logic ce_q = 1'b1, oe_q = 1'b1, doe_q = 1'b0, vpp_q = 1'b0;
  int pw_run = 0, su_run = 0, hd_run = 0, gap_run = 1000, vl_run = 0;
  int pw_bad = 0, su_bad = 0, hd_bad = 0, gap_bad = 0, vl_bad = 0, npulses = 0;
  bit after_pulse = 0, saw_drive = 0, vl_arm = 0;

  assign mem_rdata = mem_oe_n ? '1 : mem[mem_addr];

  always @(posedge clk) begin
    ce_q <= mem_ce_n; oe_q <= mem_oe_n; doe_q <= mem_data_oe; vpp_q <= mem_vpp_en;
    if (mem_vpp_en && mem_ce_n && !ce_q) begin
      pcnt[mem_addr] <= pcnt[mem_addr] + 1;
      if (pcnt[mem_addr] + 1 >= need[mem_addr]) mem[mem_addr] <= mem[mem_addr] & mem_wdata;
      npulses <= npulses + 1;
      if (pw_run != T_PW) pw_bad <= pw_bad + 1;
    end
    if (!mem_vpp_en && vpp_q && corrupt_en) mem[2] <= mem[2] ^ 16'h0001;
    pw_run <= (mem_vpp_en && !mem_ce_n) ? pw_run + 1 : 0;
    // setup before chip-enable fall
    if (mem_vpp_en && !mem_ce_n && ce_q && su_run < T_SU) su_bad <= su_bad + 1;
    su_run <= (mem_data_oe && mem_ce_n) ? su_run + 1 : 0;
    // hold after chip-enable rise
    if (mem_vpp_en && mem_ce_n && !ce_q) after_pulse <= 1'b1;
    if (mem_data_oe && mem_ce_n && (after_pulse || !ce_q)) hd_run <= hd_run + 1;
    if (!mem_data_oe && doe_q) begin
      if (hd_run < T_HD) hd_bad <= hd_bad + 1;
      hd_run <= 0; after_pulse <= 1'b0;
    end
    // gap from data release to output-enable fall
    gap_run <= mem_data_oe ? 0 : gap_run + 1;
    if (mem_data_oe) saw_drive <= 1'b1;
    if (!mem_oe_n && oe_q) begin
      if (mem_vpp_en && saw_drive && gap_run < T_SU) gap_bad <= gap_bad + 1;
      saw_drive <= 1'b0;
    end
    // supply lead before first read
    if (mem_vpp_en && !vpp_q) begin vl_arm <= 1'b1; vl_run <= 1; end
    else if (mem_vpp_en && vl_arm) begin
      if (!mem_oe_n) begin
        if (vl_run < 2 * T_SU) vl_bad <= vl_bad + 1;
        vl_arm <= 1'b0;
      end else vl_run <= vl_run + 1;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_range(input logic [AW-1:0] f, input logic [AW-1:0] l, output bit to);
    @(negedge clk);
    first_addr = f; last_addr = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0 && fail === 1'b0, "R10", "busy after start", busy, 1);
    to = 1'b1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done || fail) begin to = 1'b0; break; end
    end
    if (to) chk(1'b0, "R4", "run timed out", 0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit to;
    row_t r;
    for (int a = 0; a < 16; a++) begin mem[a] = '1; need[a] = 1; pcnt[a] = 0; end
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && fail === 1'b0, "R11", "status in reset", {busy, done, fail}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_vpp_en === 1'b0 && busy === 1'b0, "R11", "supply/busy after reset", {mem_vpp_en, busy}, 0);
    chk(mem_ce_n === 1'b1 && mem_oe_n === 1'b1, "R11", "strobes after reset", {mem_ce_n, mem_oe_n}, 3);

    for (int k = 0; k < NROWS; k++) begin
      r = ROWS[k];
      for (int a = int'(r.first); a <= int'(r.last); a++) need[a] = int'(r.base) + (a % 4) * int'(r.step);
      if (r.preset == 2'd1) mem[r.last] = '0;
      if (r.preset == 2'd2) mem[r.last] = img(r.last);
      run_range(r.first, r.last, to);
      chk(fail === r.exp_fail && done === !r.exp_fail, "R4", $sformatf("row %0d done/fail", k),
          {done, fail}, {!r.exp_fail, r.exp_fail});
      chk(fail_cause === r.exp_cause, "R3", $sformatf("row %0d fail_cause", k), fail_cause, r.exp_cause);
      chk(pulses_used === r.exp_pulses, "R3", $sformatf("row %0d pulses_used", k), pulses_used, r.exp_pulses);
      if (r.exp_fail)
        chk(fail_addr === r.exp_addr, "R3", $sformatf("row %0d fail_addr", k), fail_addr, r.exp_addr);
      else
        for (int a = int'(r.first); a <= int'(r.last); a++)
          chk(mem[a] === img(AW'(a)), "R4", $sformatf("word %0d content", a), mem[a], img(AW'(a)));
      if (r.preset == 2'd1) chk(pcnt[r.last] == 0, "R7", "pulses on blocked word", pcnt[r.last], 0);
      if (r.preset == 2'd2) chk(pcnt[r.last] == 0, "R8", "pulses on matching word", pcnt[r.last], 0);
      repeat (5) @(negedge clk);
      chk(done === !r.exp_fail && fail === r.exp_fail && mem_vpp_en === 1'b0, "R10",
          $sformatf("row %0d status held", k), {done, fail, mem_vpp_en}, {!r.exp_fail, r.exp_fail, 1'b0});
    end

    // final read-back catches a word disturbed after the program pass
    corrupt_en = 1'b1;
    run_range(4'd0, 4'd3, to);
    corrupt_en = 1'b0;
    chk(fail === 1'b1 && fail_cause === 2'd3, "R9", "read-back cause", fail_cause, 3);
    chk(fail_addr === 4'd2, "R9", "read-back address", fail_addr, 2);
    chk(pulses_used === 5'd0, "R8", "already-programmed range pulses", pulses_used, 0);

    chk(npulses > 0 && pw_bad == 0, "R1", "pulse width violations", pw_bad, 0);
    chk(su_bad == 0 && vl_bad == 0, "R5", "setup violations", su_bad + vl_bad, 0);
    chk(hd_bad == 0 && gap_bad == 0, "R6", "hold/gap violations", hd_bad + gap_bad, 0);
    chk(pcnt[10] == MAXP, "R2", "verify after every pulse on failing word", pcnt[10], MAXP);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule